// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models, in synthesizable form, the embedded controller of a parallel NOR flash array. The host bus signals (address, 16-bit write data, active-low chip, write and output strobes) are sampled in the block's clock domain. A completed host write cycle is taken at the rising edge of the write strobe while chip select is low. The sequencer decodes these writes into word-program, sector-erase, bypass-program and erase suspend/resume commands. It then runs a timed operation against a small on-chip array.

While an operation runs, reads return a status word instead of array data. The host polls that word until it sees the data it wrote. Sectors can be write-protected in any combination through a mask input. A low-supply input blocks all command processing. Program and erase durations are parameters counted in clock cycles.

The bus is a plain strobe interface with no back-pressure. The host learns that the block is busy only by polling the status word, and any write it issues during a busy period is dropped, with one exception: a suspend request during an erase.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset every word reads 16'hFFFF, no operation is running, and `dout` is 0 whenever `ce_n` or `oe_n` is high.
- R2: The four writes 8'hAA at address 5'h15, 8'h55 at 5'h0A, 8'hA0 at 5'h15, then the data at the target address program one word. The stored value is the old word ANDed with the written data.
- R3: While a program or erase runs, a read at any address returns a status word. Bit 7 is the complement of bit 7 of the target data (0 during an erase). Bit 6 changes between successive reads. All other bits are 0.
- R4: The six writes AA@15h, 55@0Ah, 80h@15h, AA@15h, 55@0Ah, then 30h at any address inside a sector set every word of that sector to 16'hFFFF. They leave all other sectors unchanged. The sector is given by the top `SECT_W` address bits.
- R5: AA@15h, 55@0Ah, 20h@15h enter bypass. In bypass, A0h at any address followed by the data at the target address programs a word. Writing 90h then 00h leaves bypass, after which a two-write program has no effect.
- R6: Writing B0h during an erase suspends it. While suspended, words outside the erasing sector read as array data and can be programmed, after which the block returns to suspension. Writing 30h resumes and completes the erase.
- R7: A program aimed at the erasing sector while the erase is suspended is ignored.
- R8: Program or erase commands aimed at a sector whose bit in `prot` is 1 are ignored: no operation starts and the data are unchanged.
- R9: While `vlow` is 1, host writes have no effect.
- R10: A write that does not match the next expected step of a sequence returns the sequencer to array-read mode. A later write without the unlock prefix does not program.
- R11: A suspend write that lands in the final cycle of an erase is ignored. The erase completes and the block does not enter suspension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address for reads and writes |
| din | input | DW | Host write data |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; its rising edge completes a write |
| oe_n | input | 1 | Output strobe, active low |
| vlow | input | 1 | Low-supply indication; blocks writes |
| prot | input | 2**SECT_W | Per-sector write protection mask |
| dout | output | DW | Read data or status word |

## Verification
The collision case is a suspend request that reaches the engine in the same cycle as the erase finishes. The bench counts clock edges from the last write of an erase command and places the rising edge of the B0h write on exactly the edge where the erase commits. It then reads a word from the erased sector. If the block had entered suspension, the old data would still show. The bench therefore expects 16'hFFFF, and it expects a following program to run as a normal, unsuspended operation.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    Q_READ, Q_UNL1, Q_UNL2, Q_PGM, Q_ER1, Q_ER2, Q_ER3, Q_BYPX
  } seq_st_t;

  typedef enum logic [2:0] {
    E_IDLE, E_PROG, E_ERASE, E_SUSP, E_SPROG
  } eng_st_t;

  localparam logic [7:0] CMD_UNLK1  = 8'hAA;
  localparam logic [7:0] CMD_UNLK2  = 8'h55;
  localparam logic [7:0] CMD_PGM    = 8'hA0;
  localparam logic [7:0] CMD_ERSET  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_BYPEX  = 8'h90;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;

endpackage

// File: rtl/fcs_bus_sample.sv
module fcs_bus_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_evt,
  output logic rd_end
);
  logic we_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end

  // write completes on the rising strobe edge with the chip selected
  assign wr_evt = !ce_n && we_n && !we_q;
  assign rd_end = oe_n && !oe_q;
endmodule

// File: rtl/fcs_decoder.sv
module fcs_decoder
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SECT_W = 2,
  parameter int DW     = 16,
  parameter logic [ADDR_W-1:0] UNL_A1 = 'h15,
  parameter logic [ADDR_W-1:0] UNL_A2 = 'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     data,
  input  logic              eng_busy,
  input  logic              eng_erasing,
  input  logic              eng_susp,
  input  logic [SECT_W-1:0] susp_sect,
  input  logic [(2**SECT_W)-1:0] prot,
  output logic              pgm_go,
  output logic              ers_go,
  output logic              susp_go,
  output logic              res_go
);
  seq_st_t st, nxt;
  logic byp, byp_nxt;
  logic [7:0] cmd;
  logic [SECT_W-1:0] tgt;

  assign cmd = data[7:0];
  assign tgt = addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    nxt     = st;
    byp_nxt = byp;
    pgm_go  = 1'b0;
    ers_go  = 1'b0;
    susp_go = 1'b0;
    res_go  = 1'b0;
    if (evt) begin
      nxt = Q_READ;
      if (eng_busy) begin
        if (eng_erasing && cmd == CMD_SUSP) susp_go = 1'b1;
      end else begin
        unique case (st)
          Q_READ: begin
            if (eng_susp && cmd == CMD_RESUME) res_go = 1'b1;
            else if (byp) begin
              if (cmd == CMD_PGM) nxt = Q_PGM;
              else if (cmd == CMD_BYPEX) nxt = Q_BYPX;
            end else if (cmd == CMD_UNLK1 && addr == UNL_A1) nxt = Q_UNL1;
          end
          Q_UNL1: if (cmd == CMD_UNLK2 && addr == UNL_A2) nxt = Q_UNL2;
          Q_UNL2: begin
            if (addr == UNL_A1) begin
              if (cmd == CMD_PGM) nxt = Q_PGM;
              else if (cmd == CMD_ERSET && !eng_susp) nxt = Q_ER1;
              else if (cmd == CMD_BYPASS) byp_nxt = 1'b1;
            end
          end
          Q_PGM:
            if (!prot[tgt] && !(eng_susp && tgt == susp_sect)) pgm_go = 1'b1;
          Q_ER1: if (cmd == CMD_UNLK1 && addr == UNL_A1) nxt = Q_ER2;
          Q_ER2: if (cmd == CMD_UNLK2 && addr == UNL_A2) nxt = Q_ER3;
          Q_ER3: if (cmd == CMD_SECT && !prot[tgt]) ers_go = 1'b1;
          Q_BYPX: if (cmd == 8'h00) byp_nxt = 1'b0;
          default: nxt = Q_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= Q_READ;
      byp <= 1'b0;
    end else begin
      st  <= nxt;
      byp <= byp_nxt;
    end
  end
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int SECT_W    = 2,
  parameter int DW        = 16,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_go,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [DW-1:0]     pgm_data,
  input  logic              ers_go,
  input  logic [SECT_W-1:0] ers_sect,
  input  logic              susp_go,
  input  logic              res_go,
  output logic              busy,
  output logic              erasing,
  output logic              susp,
  output logic              poll_bit,
  output logic [SECT_W-1:0] esect,
  output logic              commit_pgm,
  output logic              commit_ers,
  output logic [ADDR_W-1:0] pa_q,
  output logic [DW-1:0]     pd_q
);
  localparam int PCW = $clog2(PROG_CYC + 1);
  localparam int ECW = $clog2(ERASE_CYC + 1);

  eng_st_t st;
  logic [PCW-1:0] pcnt;
  logic [ECW-1:0] ecnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= E_IDLE;
      pcnt  <= '0;
      ecnt  <= '0;
      pa_q  <= '0;
      pd_q  <= '0;
      esect <= '0;
    end else begin
      unique case (st)
        E_IDLE: begin
          if (pgm_go) begin
            st   <= E_PROG;
            pcnt <= PCW'(PROG_CYC - 1);
            pa_q <= pgm_addr;
            pd_q <= pgm_data;
          end else if (ers_go) begin
            st    <= E_ERASE;
            ecnt  <= ECW'(ERASE_CYC - 1);
            esect <= ers_sect;
          end
        end
        E_PROG:
          if (pcnt == '0) st <= E_IDLE;
          else pcnt <= pcnt - 1'b1;
        E_ERASE:
          if (ecnt == '0) st <= E_IDLE;          // completion beats suspend
          else if (susp_go) st <= E_SUSP;
          else ecnt <= ecnt - 1'b1;
        E_SUSP: begin
          if (pgm_go) begin
            st   <= E_SPROG;
            pcnt <= PCW'(PROG_CYC - 1);
            pa_q <= pgm_addr;
            pd_q <= pgm_data;
          end else if (res_go) st <= E_ERASE;
        end
        E_SPROG:
          if (pcnt == '0) st <= E_SUSP;
          else pcnt <= pcnt - 1'b1;
        default: st <= E_IDLE;
      endcase
    end
  end

  assign busy       = (st == E_PROG) || (st == E_ERASE) || (st == E_SPROG);
  assign erasing    = (st == E_ERASE);
  assign susp       = (st == E_SUSP);
  assign poll_bit   = erasing ? 1'b1 : pd_q[7];
  assign commit_pgm = ((st == E_PROG) || (st == E_SPROG)) && (pcnt == '0);
  assign commit_ers = erasing && (ecnt == '0);
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int ADDR_W = 5,
  parameter int SECT_W = 2,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_we,
  input  logic [ADDR_W-1:0] pa,
  input  logic [DW-1:0]     pd,
  input  logic              ers_we,
  input  logic [SECT_W-1:0] es,
  input  logic [ADDR_W-1:0] ra,
  output logic [DW-1:0]     rd_data
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam int WBW   = ADDR_W - SECT_W;
  localparam int WPS   = 2 ** WBW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (pgm_we) mem[pa] <= mem[pa] & pd;   // cells can only go 1 -> 0
      if (ers_we)
        for (int w = 0; w < WPS; w++) mem[{es, WBW'(w)}] <= '1;
    end
  end

  assign rd_data = mem[ra];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W    = 5,
  parameter int SECT_W    = 2,
  parameter int DW        = 16,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60,
  parameter logic [ADDR_W-1:0] UNL_A1 = 'h15,
  parameter logic [ADDR_W-1:0] UNL_A2 = 'h0A
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DW-1:0]          din,
  input  logic                   ce_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic                   vlow,
  input  logic [(2**SECT_W)-1:0] prot,
  output logic [DW-1:0]          dout
);
  logic wr_evt, rd_end, evt;
  logic pgm_go, ers_go, susp_go, res_go;
  logic busy, erasing, susp, poll_bit, commit_pgm, commit_ers;
  logic [SECT_W-1:0] esect, cmd_sect;
  logic [ADDR_W-1:0] pa_q;
  logic [DW-1:0] pd_q, rd_data;
  logic tog, rd_act;

  assign evt      = wr_evt && !vlow;
  assign cmd_sect = addr[ADDR_W-1 -: SECT_W];
  assign rd_act   = !ce_n && !oe_n;

  fcs_bus_sample i_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_evt(wr_evt), .rd_end(rd_end)
  );

  fcs_decoder #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DW(DW), .UNL_A1(UNL_A1), .UNL_A2(UNL_A2)
  ) i_dec (
    .clk(clk), .rst_n(rst_n), .evt(evt), .addr(addr), .data(din),
    .eng_busy(busy), .eng_erasing(erasing), .eng_susp(susp),
    .susp_sect(esect), .prot(prot),
    .pgm_go(pgm_go), .ers_go(ers_go), .susp_go(susp_go), .res_go(res_go)
  );

  fcs_engine #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DW(DW),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_eng (
    .clk(clk), .rst_n(rst_n),
    .pgm_go(pgm_go), .pgm_addr(addr), .pgm_data(din),
    .ers_go(ers_go), .ers_sect(cmd_sect), .susp_go(susp_go), .res_go(res_go),
    .busy(busy), .erasing(erasing), .susp(susp), .poll_bit(poll_bit),
    .esect(esect), .commit_pgm(commit_pgm), .commit_ers(commit_ers),
    .pa_q(pa_q), .pd_q(pd_q)
  );

  fcs_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DW(DW)) i_arr (
    .clk(clk), .rst_n(rst_n),
    .pgm_we(commit_pgm), .pa(pa_q), .pd(pd_q),
    .ers_we(commit_ers), .es(esect), .ra(addr), .rd_data(rd_data)
  );

  // status toggle advances once per completed read while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else if (rd_end && busy) tog <= ~tog;
  end

  always_comb begin
    dout = '0;
    if (rd_act) begin
      if (busy) begin
        dout[7] = ~poll_bit;
        dout[6] = tog;
      end else begin
        dout = rd_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int SECT_W = 2,
  parameter int DW     = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   vlow,
  input logic                   busy,
  input logic                   susp,
  input logic                   erasing,
  input logic                   pgm_go,
  input logic                   ers_go,
  input logic                   rd_act,
  input logic [SECT_W-1:0]      cmd_sect,
  input logic [SECT_W-1:0]      esect,
  input logic [(2**SECT_W)-1:0] prot,
  input logic [DW-1:0]          dout
);
  a_r9_vlow_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (vlow && !busy && !susp) |=> (!busy && !susp));

  a_r9_vlow_susp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (vlow && susp) |=> susp);

  a_r8_prot_pgm: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_go |-> !prot[cmd_sect]);

  a_r8_prot_ers: assert property (@(posedge clk) disable iff (!rst_n)
    ers_go |-> !prot[cmd_sect]);

  a_r7_susp_pgm_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && pgm_go) |-> (cmd_sect != esect));

  a_r6_susp_leaves_to_erase: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> (susp || erasing || busy));

  a_r3_status_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && busy) |-> (dout[DW-1:8] == '0 && dout[5:0] == '0));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.SECT_W(SECT_W), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .vlow(vlow), .busy(busy), .susp(susp),
  .erasing(erasing), .pgm_go(pgm_go), .ers_go(ers_go), .rd_act(rd_act),
  .cmd_sect(cmd_sect), .esect(esect), .prot(prot), .dout(dout)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int CLK_PER = 10;
  localparam int ERS     = 80;
  localparam logic [4:0] A1 = 5'h15;
  localparam logic [4:0] A2 = 5'h0A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] din = '0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vlow = 1'b0;
  logic [3:0] prot = '0;
  logic [15:0] dout;

  int nchk = 0, nfail = 0, cyc = 0, last_evt = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic [15:0] cap;
  event rd_ev;

  flash_cmd_seq #(.PROG_CYC(20), .ERASE_CYC(ERS)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .we_n(we_n), .oe_n(oe_n), .vlow(vlow), .prot(prot), .dout(dout)
  );

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each captured read
  initial forever begin
    @(rd_ev);
    chk(cap == exp_q[0], tag_q[0], cap, exp_q[0]);
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
  end

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; last_evt = cyc + 1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_write_at(input logic [4:0] a, input logic [15:0] d, input int tgt);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    while (cyc < tgt - 1) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = dout; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic sb_read(input logic [4:0] a, input logic [15:0] e, input string tag);
    logic [15:0] v;
    bus_read(a, v);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cap = v;
    ->rd_ev;
  endtask

  task automatic wait_ready(input logic [4:0] a, input logic [15:0] e);
    logic [15:0] v;
    for (int k = 0; k < 400; k++) begin
      bus_read(a, v);
      if (v == e) break;
    end
  endtask

  task automatic program4(input logic [4:0] a, input logic [15:0] d);
    bus_write(A1, 16'h00AA); bus_write(A2, 16'h0055);
    bus_write(A1, 16'h00A0); bus_write(a, d);
  endtask

  task automatic erase6(input logic [4:0] sa);
    bus_write(A1, 16'h00AA); bus_write(A2, 16'h0055); bus_write(A1, 16'h0080);
    bus_write(A1, 16'h00AA); bus_write(A2, 16'h0055); bus_write(sa, 16'h0030);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] r1, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); addr = 5'd3; oe_n = 1'b0;
    @(negedge clk); chk(dout == 16'h0, "R1 deselected", dout, 16'h0); oe_n = 1'b1;
    sb_read(5'd0, 16'hFFFF, "R1 reset word 0");
    sb_read(5'd31, 16'hFFFF, "R1 reset word 31");

    // R2 program, R3 status during program
    program4(5'd3, 16'h1234);
    bus_read(5'd3, r1);
    bus_read(5'd3, r2);
    chk((r1 & 16'hFFBF) == 16'h0080, "R3 program status word", r1, 16'h0080);
    chk(r1[6] != r2[6], "R3 toggle bit", r2, r1 ^ 16'h0040);
    wait_ready(5'd3, 16'h1234);
    sb_read(5'd3, 16'h1234, "R2 programmed word");
    program4(5'd3, 16'hFF0F);
    wait_ready(5'd3, 16'h1204);
    sb_read(5'd3, 16'h1204, "R2 AND with old data");

    // R4 erase sector 0, R3 erase status
    program4(5'd9, 16'hABCD);
    wait_ready(5'd9, 16'hABCD);
    erase6(5'd2);
    bus_read(5'd5, r1);
    chk((r1 & 16'hFFBF) == 16'h0000, "R3 erase status word", r1, 16'h0000);
    wait_ready(5'd3, 16'hFFFF);
    sb_read(5'd3, 16'hFFFF, "R4 erased word");
    sb_read(5'd9, 16'hABCD, "R4 other sector kept");

    // R5 bypass
    bus_write(A1, 16'h00AA); bus_write(A2, 16'h0055); bus_write(A1, 16'h0020);
    bus_write(5'd0, 16'h00A0); bus_write(5'd17, 16'h5555);
    wait_ready(5'd17, 16'h5555);
    sb_read(5'd17, 16'h5555, "R5 two-write program");
    bus_write(5'd0, 16'h0090); bus_write(5'd0, 16'h0000);
    bus_write(5'd0, 16'h00A0); bus_write(5'd17, 16'h0000);
    sb_read(5'd17, 16'h5555, "R5 after exit no program");

    // R10 broken sequence
    bus_write(A1, 16'h00AA); bus_write(A2, 16'h0055); bus_write(A1, 16'h0077);
    bus_write(A1, 16'h00A0); bus_write(5'd20, 16'h0000);
    sb_read(5'd20, 16'hFFFF, "R10 aborted sequence");

    // R8 protection
    program4(5'd26, 16'h00F0);
    wait_ready(5'd26, 16'h00F0);
    prot = 4'b1000;
    program4(5'd25, 16'h0000);
    sb_read(5'd25, 16'hFFFF, "R8 protected program ignored");
    erase6(5'd24);
    sb_read(5'd26, 16'h00F0, "R8 protected erase ignored");
    prot = 4'b0000;

    // R9 low supply
    vlow = 1'b1;
    program4(5'd21, 16'h0000);
    sb_read(5'd21, 16'hFFFF, "R9 low supply blocks");
    vlow = 1'b0;

    // R6 / R7 suspend and resume on sector 1
    erase6(5'd8);
    bus_write(5'd0, 16'h00B0);
    sb_read(5'd9, 16'hABCD, "R6 suspended read array");
    program4(5'd12, 16'h0000);
    sb_read(5'd12, 16'hFFFF, "R7 program in erasing sector ignored");
    program4(5'd4, 16'h0F0F);
    wait_ready(5'd4, 16'h0F0F);
    sb_read(5'd4, 16'h0F0F, "R6 program during suspend");
    sb_read(5'd9, 16'hABCD, "R6 still suspended");
    bus_write(5'd0, 16'h0030);
    wait_ready(5'd9, 16'hFFFF);
    sb_read(5'd9, 16'hFFFF, "R6 resumed erase done");

    // R11 suspend collides with erase completion
    erase6(5'd16);
    bus_write_at(5'd0, 16'h00B0, last_evt + ERS);
    sb_read(5'd17, 16'hFFFF, "R11 erase completes over suspend");
    program4(5'd18, 16'h1111);
    wait_ready(5'd18, 16'h1111);
    sb_read(5'd18, 16'h1111, "R11 normal operation after");

    @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule